// File: doc/BRIEF.md
# Shared Assignable Timer Prescaler

This block holds a single 8-bit divide counter that is lent to one of two consumers at a time: an 8-bit timer or a watchdog timer. A one-bit route control picks which consumer the counter serves, and a 3-bit rate code picks a power-of-two division ratio. The consumer that does not own the counter sees its raw event stream, passed through one register with no division.

The ratio table moves by one step with the route. For the timer the ratios run from 2 up to 256. For the watchdog they run from 1 up to 128. A timer rate of 1:1 is therefore obtained by giving the counter to the watchdog.

The count is cleared by whichever clear source belongs to the current owner: a timer-register write for the timer, or a watchdog-clear command for the watchdog. It is also cleared whenever the route changes. Software has no read or write path to the count. Each output pulse is one cycle wide and appears in the cycle after the event that produced it.

Top module: `shared_prescaler`

## Requirements
- R1: After reset both outputs are low, the count is zero and the counter belongs to the watchdog. With route=1 and rate code 000 applied from reset, the very first watchdog tick is passed on (no route-change clear occurs).
- R2: With route=0 (timer owns the counter), rate code c gives one tmrInc pulse per 2^(c+1) timer events. The pulse appears one cycle after the event that completes the period.
- R3: With route=1 (watchdog owns the counter), rate code c gives one wdtPulse per 2^c watchdog ticks. Code 000 passes every tick.
- R4: With route=1, every timer event gives a tmrInc pulse one cycle later, which is a 1:1 timer rate.
- R5: With route=0, every watchdog tick gives a wdtPulse one cycle later, with no division.
- R6: With route=0, a timer write clears the count. With route=1, a timer write has no effect on the count.
- R7: With route=1, a watchdog clear clears the count. With route=0, a watchdog clear has no effect on the count.
- R8: When the owner's clear and the owner's event arrive in the same cycle, the clear wins: that event is not counted and produces no pulse.
- R9: A change of the route bit clears the count. An owner event in the cycle of the change is not counted.
- R10: An output pulse only occurs in the cycle after an event on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tmrEvent | input | 1 | Timer source event, one cycle per edge, already edge-selected |
| wdtTick | input | 1 | Watchdog oscillator tick, one cycle wide |
| routeWdt | input | 1 | 0 = counter serves the timer, 1 = counter serves the watchdog |
| rateCode | input | 3 | Division ratio code |
| tmrWrite | input | 1 | Strobe: the timer count register was written |
| wdtClear | input | 1 | Strobe: watchdog-clear command |
| tmrInc | output | 1 | Timer increment pulse |
| wdtPulse | output | 1 | Watchdog tick pulse |

## Verification
The owner's clear strobe and the owner's counting event can fall in the same cycle. The same holds for a route change and an event of the new owner. The bench drives the event together with a timer write while the timer owns the counter. It also flips the route in the same cycle as a watchdog tick. In both cases it expects no pulse in the following cycle, and expects a full fresh period to be needed before the next pulse, which shows that the colliding event was dropped and not counted.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  // Strobes passed from control to the datapath each cycle
  typedef struct packed {
    logic clrCnt;    // zero the divide counter
    logic advance;   // owner event: count one step
    logic routeWdt;  // current owner, 1 = watchdog
  } preStrobe_t;
endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import prescaler_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int CNT_W  = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrEvent,
  input  logic              wdtTick,
  input  logic              routeWdt,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              tmrWrite,
  input  logic              wdtClear,
  output preStrobe_t        strobe,
  output logic [CNT_W-1:0]  termMask
);
  localparam int SHIFT_W = $clog2(CNT_W + 1);

  logic               routeQ;
  logic               routeSwap;
  logic [SHIFT_W-1:0] shiftAmt;

  // Remember the previous owner; the reset owner is the watchdog
  always_ff @(posedge clk) begin
    if (!rstN) routeQ <= 1'b1;
    else       routeQ <= routeWdt;
  end

  assign routeSwap = routeWdt != routeQ;

  always_comb begin
    strobe.routeWdt = routeWdt;
    strobe.advance  = routeWdt ? wdtTick : tmrEvent;
    strobe.clrCnt   = routeSwap
                    | (!routeWdt && tmrWrite)
                    | ( routeWdt && wdtClear);
  end

  // The timer table sits one doubling above the watchdog table
  assign shiftAmt = SHIFT_W'(rateCode) + SHIFT_W'(!routeWdt);

  // The low shiftAmt bits of the mask are set
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign termMask[i] = shiftAmt > SHIFT_W'(i);
  end

  AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (routeWdt != routeQ) |-> strobe.clrCnt); // R9
endmodule

// File: rtl/presc_datapath.sv
module presc_datapath
  import prescaler_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  preStrobe_t       strobe,
  input  logic [CNT_W-1:0] termMask,
  input  logic             tmrEvent,
  input  logic             wdtTick,
  output logic             tmrInc,
  output logic             wdtPulse
);
  logic [CNT_W-1:0] cnt;
  logic             atTerm;
  logic             periodDone;

  assign atTerm     = (cnt & termMask) == termMask;
  assign periodDone = strobe.advance && atTerm && !strobe.clrCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.clrCnt)  cnt <= '0;
    else if (strobe.advance) cnt <= periodDone ? '0 : cnt + 1'b1;
  end

  // Owner gets the divided pulse; the other consumer gets its raw event
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrInc   <= 1'b0;
      wdtPulse <= 1'b0;
    end else begin
      tmrInc   <= strobe.routeWdt ? tmrEvent   : periodDone;
      wdtPulse <= strobe.routeWdt ? periodDone : wdtTick;
    end
  end

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> (cnt == '0)); // R6
  AST_TMR_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.routeWdt && tmrEvent) |=> tmrInc); // R4
  AST_WDT_BYPASS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.routeWdt && wdtTick) |=> wdtPulse); // R5
  AST_TMR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    tmrInc |-> $past(tmrEvent)); // R10
  AST_WDT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    wdtPulse |-> $past(wdtTick)); // R10
  AST_CLEAR_BLOCKS_TMR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrCnt && !strobe.routeWdt) |=> !tmrInc); // R8
  AST_CLEAR_BLOCKS_WDT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrCnt && strobe.routeWdt) |=> !wdtPulse); // R8
endmodule

// File: rtl/shared_prescaler.sv
module shared_prescaler
  import prescaler_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int CNT_W  = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tmrEvent,
  input  logic              wdtTick,
  input  logic              routeWdt,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              tmrWrite,
  input  logic              wdtClear,
  output logic              tmrInc,
  output logic              wdtPulse
);
  preStrobe_t       strobe;
  logic [CNT_W-1:0] termMask;

  presc_ctrl #(.RATE_W(RATE_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .tmrEvent(tmrEvent), .wdtTick(wdtTick),
    .routeWdt(routeWdt), .rateCode(rateCode), .tmrWrite(tmrWrite),
    .wdtClear(wdtClear), .strobe(strobe), .termMask(termMask)
  );

  presc_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .termMask(termMask),
    .tmrEvent(tmrEvent), .wdtTick(wdtTick),
    .tmrInc(tmrInc), .wdtPulse(wdtPulse)
  );
endmodule

// File: tb/shared_prescaler_tb.sv
`timescale 1ns/1ps
module shared_prescaler_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tmrEvent = 1'b0, wdtTick = 1'b0, tmrWrite = 1'b0, wdtClear = 1'b0;
  logic routeWdt = 1'b1;
  logic [2:0] rateCode = 3'd0;
  logic tmrInc, wdtPulse;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  shared_prescaler dut_i (
    .clk(clk), .rstN(rstN), .tmrEvent(tmrEvent), .wdtTick(wdtTick),
    .routeWdt(routeWdt), .rateCode(rateCode), .tmrWrite(tmrWrite),
    .wdtClear(wdtClear), .tmrInc(tmrInc), .wdtPulse(wdtPulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive at a falling edge, sample the registered outputs one cycle later
  task automatic cycle(input logic te, input logic wt, input logic tw, input logic wc,
                       output logic ot, output logic ow);
    tmrEvent = te; wdtTick = wt; tmrWrite = tw; wdtClear = wc;
    @(negedge clk);
    ot = tmrInc; ow = wdtPulse;
    tmrEvent = 0; wdtTick = 0; tmrWrite = 0; wdtClear = 0;
  endtask

  task automatic set_cfg(input logic r, input logic [2:0] c);
    logic ot, ow;
    routeWdt = r; rateCode = c;
    cycle(0, 0, 0, 0, ot, ow);
  endtask

  // Send n events on one input; return the 1-based index of the first pulse (0 = none)
  task automatic run_events(input bit onWdt, input int n, output int firstIdx, output int total);
    logic ot, ow;
    firstIdx = 0; total = 0;
    for (int k = 1; k <= n; k++) begin
      cycle(!onWdt, onWdt, 0, 0, ot, ow);
      if (onWdt ? ow : ot) begin
        total++;
        if (firstIdx == 0) firstIdx = k;
      end
    end
  endtask

  task automatic test_reset();
    int f, t;
    rstN = 0; tmrEvent = 1; wdtTick = 1;
    repeat (3) @(negedge clk);
    check(tmrInc == 0 && wdtPulse == 0, "R1 outputs low in reset", tmrInc + wdtPulse, 0);
    tmrEvent = 0; wdtTick = 0; rstN = 1;
    @(negedge clk);
    run_events(1, 1, f, t);
    check(f == 1, "R1 watchdog owns counter after reset", f, 1);
  endtask

  task automatic test_timer_rates();
    int f, t; logic ot, ow;
    for (int c = 0; c < 8; c++) begin
      set_cfg(0, 3'(c));
      cycle(0, 0, 1, 0, ot, ow);
      run_events(0, 1 << (c + 1), f, t);
      check(f == (1 << (c + 1)) && t == 1, "R2 timer ratio", f, 1 << (c + 1));
    end
  endtask

  task automatic test_wdt_rates();
    int f, t; logic ot, ow;
    for (int c = 0; c < 8; c++) begin
      set_cfg(1, 3'(c));
      cycle(0, 0, 0, 1, ot, ow);
      run_events(1, 1 << c, f, t);
      check(f == (1 << c) && t == 1, "R3 watchdog ratio", f, 1 << c);
    end
  endtask

  task automatic test_bypass();
    int f, t;
    set_cfg(1, 3'd5);
    run_events(0, 5, f, t);
    check(t == 5 && f == 1, "R4 timer 1:1 when watchdog owns", t, 5);
    set_cfg(0, 3'd5);
    run_events(1, 6, f, t);
    check(t == 6 && f == 1, "R5 watchdog undivided when timer owns", t, 6);
  endtask

  task automatic test_timer_write();
    int f, t; logic ot, ow;
    set_cfg(0, 3'd1);                      // timer ratio 4
    cycle(0, 0, 1, 0, ot, ow);
    run_events(0, 3, f, t);
    cycle(0, 0, 1, 0, ot, ow);             // clear
    run_events(0, 4, f, t);
    check(f == 4, "R6 timer write restarts count", f, 4);
    set_cfg(1, 3'd2);                      // watchdog ratio 4
    cycle(0, 0, 0, 1, ot, ow);
    run_events(1, 3, f, t);
    cycle(0, 0, 1, 0, ot, ow);             // ignored
    run_events(1, 1, f, t);
    check(f == 1, "R6 timer write ignored when watchdog owns", f, 1);
  endtask

  task automatic test_wdt_clear();
    int f, t; logic ot, ow;
    set_cfg(1, 3'd2);
    cycle(0, 0, 0, 1, ot, ow);
    run_events(1, 3, f, t);
    cycle(0, 0, 0, 1, ot, ow);
    run_events(1, 4, f, t);
    check(f == 4, "R7 watchdog clear restarts count", f, 4);
    set_cfg(0, 3'd1);
    cycle(0, 0, 1, 0, ot, ow);
    run_events(0, 3, f, t);
    cycle(0, 0, 0, 1, ot, ow);             // ignored
    run_events(0, 1, f, t);
    check(f == 1, "R7 watchdog clear ignored when timer owns", f, 1);
  endtask

  task automatic test_collision();
    int f, t; logic ot, ow;
    set_cfg(0, 3'd0);                      // timer ratio 2
    cycle(0, 0, 1, 0, ot, ow);
    run_events(0, 1, f, t);
    cycle(1, 0, 1, 0, ot, ow);             // event with clear
    check(ot == 0, "R8 clear beats completing event", ot, 0);
    run_events(0, 2, f, t);
    check(f == 2, "R8 colliding event not counted", f, 2);
  endtask

  task automatic test_switch();
    int f, t; logic ot, ow;
    set_cfg(0, 3'd2);                      // timer ratio 8
    cycle(0, 0, 1, 0, ot, ow);
    run_events(0, 7, f, t);
    routeWdt = 1;                          // watchdog ratio 4
    cycle(0, 1, 0, 0, ot, ow);
    check(ow == 0, "R9 tick in swap cycle gives no pulse", ow, 0);
    run_events(1, 4, f, t);
    check(f == 4, "R9 swap restarts count", f, 4);
  endtask

  task automatic test_quiet();
    int seen = 0; logic ot, ow;
    set_cfg(1, 3'd0);
    for (int k = 0; k < 10; k++) begin
      cycle(0, 0, k[0], k[1], ot, ow);
      seen += int'(ot) + int'(ow);
    end
    check(seen == 0, "R10 no pulse without an event", seen, 0);
  endtask

  initial begin
    #(20 * 200000);
    check(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    test_reset();
    test_timer_rates();
    test_wdt_rates();
    test_bypass();
    test_timer_write();
    test_wdt_clear();
    test_collision();
    test_switch();
    test_quiet();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule